// File: doc/BRIEF.md
# Framed Serial Shifter Pair

This block pairs a transmit shifter and a receive shifter that share one externally generated shift clock. Both work on a single open-drain data line of the two-wire serial bus commonly called I2C. The transmit side takes a byte from a one-entry write buffer. It sends a frame made of a low start slot, the eight data bits with the most significant bit first, and a trailing slot. The trailing slot is driven low for an acknowledge or released high for a not-acknowledge. Its value comes from a live configuration bit, so software can change it while a frame is in flight. Writing all ones releases the line for the whole data field, which lets a slave drive read data onto it.

The receive side watches the same line. It samples on the falling edges of the shift clock during the data and trailing slots, and ignores the start slot. It places the byte into a read buffer and raises a full flag. When the sampled trailing bit differs from the expected value, it also raises a sticky error flag, which software reads as a missing acknowledge. The write port is valid/ready: a byte is accepted only while the buffer is empty, and `tx_ready` stays low until the shifter takes the byte. The read port cannot hold back the bus. A byte left unread is overwritten by the next frame, and `rx_ready` only drains the buffer. Edge detection of the shift clock is done in the system clock domain. Clock generation and START/STOP sequencing belong to other logic.

Top module: `ffsp_shifter_pair`

## Requirements
- R1: After reset, `sda_oe` is 0, `stat_flags` is 0, `err_flag` is 0, `tx_ready` is 1, `rx_valid` is 0, and both interrupts are 0.
- R2: A frame starts on a shift-clock rising edge while `tx_en` is 1 and the write buffer holds a byte. Slot 0 drives the line low (`sda_oe`=1). Slots 1..8 carry the data bits from `tx_data[7]` down to `tx_data[0]`: a 0 bit drives low and a 1 bit releases the line. Each slot starts on a rising edge.
- R3: Slot 9 releases the line when `tx_stop_hi` is 1 and drives it low when `tx_stop_hi` is 0, using the value present during the slot. The line is released after slot 9 unless another byte follows.
- R4: `tx_ready` is 1 exactly while the write buffer is empty. An accepted byte is held until the shifter takes it at the start of a frame.
- R5: `stat_flags[0]` is set when the shifter takes a byte from the buffer and when `tx_en` rises. It is cleared by `stat_clr[0]`=1 or by accepting a new byte.
- R6: On the falling edges in slots 1..9 the line is sampled. After slot 9, `rx_data` holds the eight data bits with the first-received bit in bit 7, and `rx_valid` (`stat_flags[1]`) is 1.
- R7: A handshake with `rx_valid` and `rx_ready` both 1, or `stat_clr[1]`=1, clears `rx_valid`.
- R8: `err_flag` is set when the bit sampled in slot 9 differs from `rx_expect_hi`. It stays set until `err_clr`=1.
- R9: `irq_stat` equals the OR of `stat_flags & stat_ie`, and `irq_err` equals `err_flag & err_ie`.
- R10: While `tx_en` is 0, the line is released, no frame starts, and a frame in progress is abandoned. The write buffer keeps its byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Shift clock, synchronous to clk |
| sda_in | input | 1 | Sensed level of the data line |
| sda_oe | output | 1 | 1 pulls the data line low |
| tx_en | input | 1 | Transmit mode enable |
| tx_stop_hi | input | 1 | Trailing slot value sent: 0 drive low, 1 release |
| rx_expect_hi | input | 1 | Expected trailing bit on receive |
| tx_valid | input | 1 | Write buffer data valid |
| tx_ready | output | 1 | Write buffer empty, can accept |
| tx_data | input | 8 | Byte to send, bit 7 first |
| rx_valid | output | 1 | Read buffer holds a byte |
| rx_ready | input | 1 | Consumer takes the read byte |
| rx_data | output | 8 | Received byte, first bit in bit 7 |
| stat_flags | output | 2 | Bit 0 transmit-empty flag, bit 1 receive-full flag |
| stat_clr | input | 2 | Write-one-to-clear for stat_flags |
| err_flag | output | 1 | Trailing-bit mismatch flag |
| err_clr | input | 1 | Write-one-to-clear for err_flag |
| stat_ie | input | 2 | Enables for the status interrupt |
| err_ie | input | 1 | Enable for the error interrupt |
| irq_stat | output | 1 | Status interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The assertions assume the shift clock is synchronous to the system clock. They also assume each of its high and low phases spans several system cycles, so a rising and a falling edge never fall in one cycle. The bench generates the shift clock with four system cycles per phase. It changes `tx_valid`, the clear strobes and the slave's drive only on the falling system edge, and never in a cycle that carries a shift-clock edge. The slave model changes its drive only after a rising shift edge, so the line is settled before the falling edge that samples it.

// File: rtl/ffsp_pkg.sv
package ffsp_pkg;
  // bit positions inside stat_flags
  localparam int FLG_TXE = 0;
  localparam int FLG_RXF = 1;
  localparam int NUM_FLG = 2;
endpackage

// File: rtl/ffsp_edge.sv
module ffsp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_in;
  end

  assign rise = sclk_in & ~sclk_q;
  assign fall = ~sclk_in & sclk_q;
endmodule

// File: rtl/ffsp_tx.sv
module ffsp_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rise,
  input  logic              stop_hi,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              oe,
  output logic              busy,
  output logic [$clog2(DATA_W+2)-1:0] pos,
  output logic              load
);
  localparam int POS_W = $clog2(DATA_W + 2);
  localparam logic [POS_W-1:0] LAST = POS_W'(DATA_W + 1);

  logic [DATA_W-1:0] swz, buf_q, sh_q;
  logic              buf_full_q, busy_q, line_bit;
  logic [POS_W-1:0]  pos_q;

  // bit-swapped view: the shifter then emits from bit 0
  for (genvar i = 0; i < DATA_W; i++) begin : g_swz
    assign swz[i] = wr_data[DATA_W-1-i];
  end

  assign wr_ready = ~buf_full_q;
  assign load     = en & rise & buf_full_q & (~busy_q | (pos_q == LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q      <= '0;
      buf_full_q <= 1'b0;
    end else if (load) begin
      buf_full_q <= 1'b0;
    end else if (wr_valid && !buf_full_q) begin
      buf_q      <= swz;
      buf_full_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      sh_q   <= '0;
    end else if (!en) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
    end else if (rise) begin
      if (load) begin
        sh_q   <= buf_q;
        pos_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (pos_q == LAST) begin
          busy_q <= 1'b0;
          pos_q  <= '0;
        end else begin
          pos_q <= pos_q + 1'b1;
          if (pos_q != '0) sh_q <= sh_q >> 1;
        end
      end
    end
  end

  always_comb begin
    line_bit = 1'b1;
    if (busy_q) begin
      if (pos_q == '0)       line_bit = 1'b0;
      else if (pos_q == LAST) line_bit = stop_hi;
      else                    line_bit = sh_q[0];
    end
  end

  assign oe   = en & busy_q & ~line_bit;
  assign busy = busy_q;
  assign pos  = pos_q;
endmodule

// File: rtl/ffsp_rx.sv
module ffsp_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              sda_in,
  input  logic              frame_busy,
  input  logic [$clog2(DATA_W+2)-1:0] pos,
  input  logic              expect_hi,
  input  logic              rd_ready,
  input  logic              clr_full,
  input  logic              clr_err,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              err,
  output logic              done
);
  localparam int POS_W = $clog2(DATA_W + 2);
  localparam logic [POS_W-1:0] LAST = POS_W'(DATA_W + 1);

  logic [DATA_W-1:0] sh_q, rd_q;
  logic              full_q, err_q, sample;

  assign sample = fall & frame_busy & (pos != '0);
  assign done   = sample & (pos == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      rd_q <= '0;
    end else if (done) begin
      rd_q <= sh_q;
    end else if (sample) begin
      sh_q <= {sh_q[DATA_W-2:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         full_q <= 1'b0;
    else if (done)                      full_q <= 1'b1;
    else if ((full_q && rd_ready) || clr_full) full_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             err_q <= 1'b0;
    else if (done && (sda_in != expect_hi)) err_q <= 1'b1;
    else if (clr_err)                       err_q <= 1'b0;
  end

  assign rd_data = rd_q;
  assign full    = full_q;
  assign err     = err_q;
endmodule

// File: rtl/ffsp_shifter_pair.sv
module ffsp_shifter_pair
  import ffsp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_in,
  input  logic               sda_in,
  output logic               sda_oe,
  input  logic               tx_en,
  input  logic               tx_stop_hi,
  input  logic               rx_expect_hi,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic [DATA_W-1:0]  tx_data,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic [DATA_W-1:0]  rx_data,
  output logic [NUM_FLG-1:0] stat_flags,
  input  logic [NUM_FLG-1:0] stat_clr,
  output logic               err_flag,
  input  logic               err_clr,
  input  logic [NUM_FLG-1:0] stat_ie,
  input  logic               err_ie,
  output logic               irq_stat,
  output logic               irq_err
);
  localparam int POS_W = $clog2(DATA_W + 2);

  logic             sh_rise, sh_fall, tx_load, tx_busy, rx_done, rx_full;
  logic             en_q, en_rise, txe_q;
  logic [POS_W-1:0] tx_pos;

  ffsp_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .rise(sh_rise), .fall(sh_fall)
  );

  ffsp_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .rise(sh_rise), .stop_hi(tx_stop_hi),
    .wr_valid(tx_valid), .wr_ready(tx_ready), .wr_data(tx_data),
    .oe(sda_oe), .busy(tx_busy), .pos(tx_pos), .load(tx_load)
  );

  ffsp_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .fall(sh_fall), .sda_in(sda_in),
    .frame_busy(tx_busy), .pos(tx_pos), .expect_hi(rx_expect_hi),
    .rd_ready(rx_ready), .clr_full(stat_clr[FLG_RXF]), .clr_err(err_clr),
    .rd_data(rx_data), .full(rx_full), .err(err_flag), .done(rx_done)
  );

  assign en_rise = tx_en & ~en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      txe_q <= 1'b0;
    end else begin
      en_q <= tx_en;
      if (tx_load || en_rise)                          txe_q <= 1'b1;
      else if (stat_clr[FLG_TXE] || (tx_valid && tx_ready)) txe_q <= 1'b0;
    end
  end

  assign rx_valid            = rx_full;
  assign stat_flags[FLG_TXE] = txe_q;
  assign stat_flags[FLG_RXF] = rx_full;
  assign irq_stat            = |(stat_flags & stat_ie);
  assign irq_err             = err_flag & err_ie;
endmodule

// File: rtl/ffsp_checker.sv
module ffsp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic       sda_oe,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       rx_done,
  input logic       err_flag,
  input logic       err_clr,
  input logic       stat_clr0,
  input logic       txe_flag,
  input logic       tx_load,
  input logic       en_rise
);
  a_r4_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  a_r5_clear_txe: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr0 && !tx_load && !en_rise) |=> !txe_flag);

  a_r5_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> txe_flag);

  a_r6_done_fills: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_valid);

  a_r7_read_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !rx_done) |=> !rx_valid);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  a_r10_off_released: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !sda_oe);
endmodule

bind ffsp_shifter_pair ffsp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .sda_oe(sda_oe),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_done(rx_done), .err_flag(err_flag),
  .err_clr(err_clr), .stat_clr0(stat_clr[0]), .txe_flag(stat_flags[0]),
  .tx_load(tx_load), .en_rise(en_rise)
);

// File: tb/sim_ffsp_shifter_pair.sv
`timescale 1ns/1ps
module sim_ffsp_shifter_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       slave_low = 1'b0;
  logic       sda_in, sda_oe;
  logic       tx_en = 1'b0, tx_stop_hi = 1'b0, rx_expect_hi = 1'b0;
  logic       tx_valid = 1'b0, tx_ready;
  logic [7:0] tx_data = '0;
  logic       rx_valid, rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic [1:0] stat_flags, stat_clr = '0, stat_ie = '0;
  logic       err_flag, err_clr = 1'b0, err_ie = 1'b0;
  logic       irq_stat, irq_err;
  int         n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  // wired-AND open-drain line
  assign sda_in = ~(sda_oe | slave_low);

  ffsp_shifter_pair u0 (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .sda_in(sda_in), .sda_oe(sda_oe),
    .tx_en(tx_en), .tx_stop_hi(tx_stop_hi), .rx_expect_hi(rx_expect_hi),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .stat_flags(stat_flags), .stat_clr(stat_clr), .err_flag(err_flag),
    .err_clr(err_clr), .stat_ie(stat_ie), .err_ie(err_ie),
    .irq_stat(irq_stat), .irq_err(irq_err)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half(input logic lvl);
    sclk = lvl;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_frame(input logic [7:0] txb, input logic [7:0] sb,
                           input logic slave_on, input logic stop_hi,
                           input logic exp_hi, input logic flip_stop);
    logic       pat_ok;
    logic       exp_oe, fin_stop, exp_e;
    logic [7:0] exp_d;
    pat_ok = 1'b1;
    tx_stop_hi = stop_hi;
    rx_expect_hi = exp_hi;
    tx_valid = 1'b1; tx_data = txb;
    @(negedge clk);
    tx_valid = 1'b0;
    for (int s = 0; s < 10; s++) begin
      half(1'b1);
      if (s == 5 && flip_stop) tx_stop_hi = ~tx_stop_hi;
      slave_low = slave_on && s >= 1 && s <= 8 && !sb[8-s];
      if (s == 0)      exp_oe = 1'b1;
      else if (s == 9) exp_oe = ~tx_stop_hi;
      else             exp_oe = ~txb[8-s];
      @(negedge clk);
      if (sda_oe !== exp_oe) pat_ok = 1'b0;
      half(1'b0);
    end
    slave_low = 1'b0;
    fin_stop = tx_stop_hi;
    half(1'b1);
    half(1'b0);
    exp_d = slave_on ? (txb & sb) : txb;
    exp_e = (fin_stop != exp_hi);
    // R2 R3: slot pattern on the line, then released
    chk(pat_ok, "R2/R3 slot pattern", int'(txb), int'(txb));
    chk(sda_oe == 1'b0, "R3 released after frame", int'(sda_oe), 0);
    chk(rx_valid == 1'b1, "R6 rx_valid", int'(rx_valid), 1);
    chk(rx_data == exp_d, "R6 rx_data", int'(rx_data), int'(exp_d));
    chk(err_flag == exp_e, "R8 err_flag", int'(err_flag), int'(exp_e));
    chk(irq_err == (exp_e & err_ie), "R9 irq_err", int'(irq_err), int'(exp_e & err_ie));
    if (txb[0]) stat_clr = 2'b10; else rx_ready = 1'b1;
    err_clr = 1'b1;
    @(negedge clk);
    stat_clr = '0; rx_ready = 1'b0; err_clr = 1'b0;
    chk(rx_valid == 1'b0, "R7 drain", int'(rx_valid), 0);
    chk(err_flag == 1'b0, "R8 clear", int'(err_flag), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sda_oe == 0 && stat_flags == 0 && err_flag == 0, "R1 outputs", int'(stat_flags), 0);
    chk(tx_ready == 1 && rx_valid == 0, "R1 handshake", int'(tx_ready), 1);
    chk(irq_stat == 0 && irq_err == 0, "R1 irqs", int'(irq_stat), 0);

    // R4 hold while disabled
    tx_valid = 1'b1; tx_data = 8'h00;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_ready == 0, "R4 full buffer", int'(tx_ready), 0);
    half(1'b1); half(1'b0);
    chk(tx_ready == 0 && sda_oe == 0, "R10 no frame while off", int'(sda_oe), 0);
    tx_en = 1'b1;
    @(negedge clk);
    chk(stat_flags[0] == 1, "R5 set by enable", int'(stat_flags[0]), 1);
    stat_clr = 2'b01;
    @(negedge clk);
    stat_clr = '0;
    chk(stat_flags[0] == 0, "R5 w1c", int'(stat_flags[0]), 0);
    half(1'b1);
    chk(tx_ready == 1, "R4 taken at start", int'(tx_ready), 1);
    chk(stat_flags[0] == 1, "R5 set by load", int'(stat_flags[0]), 1);
    chk(sda_oe == 1, "R2 start low", int'(sda_oe), 1);
    stat_ie = 2'b01;
    @(negedge clk);
    chk(irq_stat == 1, "R9 irq_stat on", int'(irq_stat), 1);
    stat_ie = 2'b10;
    @(negedge clk);
    chk(irq_stat == 0, "R9 irq_stat masked", int'(irq_stat), 0);
    stat_ie = 2'b00;
    half(1'b0); half(1'b1);
    chk(sda_oe == 1, "R2 data bit 0 drives", int'(sda_oe), 1);
    tx_en = 1'b0;
    @(negedge clk);
    chk(sda_oe == 0, "R10 abandon", int'(sda_oe), 0);
    half(1'b0);
    tx_en = 1'b1;
    stat_clr = 2'b01;
    @(negedge clk);
    stat_clr = '0;

    // directed: run-time trailing slot change, error interrupt
    err_ie = 1'b1;
    run_frame(8'hA5, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    run_frame(8'h3C, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    err_ie = 1'b0;

    // sweep: loopback of every byte
    for (int i = 0; i < 256; i++)
      run_frame(8'(i), 8'h00, 1'b0, i[0], i[1], 1'b0);
    // sweep: released data field, slave drives every pattern
    for (int i = 0; i < 256; i++)
      run_frame(8'hFF, 8'(i) ^ 8'h5A, 1'b1, i[2], 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule